// File: doc/BRIEF.md
# Nonvolatile Static Memory Bus Mode Controller

This block is the host-side control for a byte-wide memory in which every RAM word has a matching shadow word. Four active-low strobes (chip select, output enable, write strobe and a nonvolatile select) are decoded each cycle into one of eight bus modes. The modes are standby, RAM read, RAM write, whole-array recall, software command cycle, output off, an illegal combination and no operation. The decoded mode drives the data-enable that a pad ring uses for its tri-state buffers, and it gates writes into the RAM.

Two whole-array transfers share one sequencer. A recall copies the shadow array into RAM at one word per clock. It runs on a host command and also runs automatically when reset is released, which models power-up. A store copies RAM into the shadow array at one word per clock and is then followed by a programmable wait that stands in for the long programming time. A store is requested on a separate pulse input. While either transfer runs, `busy` is high and every host access is ignored. Both arrays are plain behavioural registers.

Top module: `nvram_bus_ctrl`

## Requirements
- R1: `data_oe` is low in every cycle where `ce_n` is high, `oe_n` is high or `ne_n` is low, and `rdata` is then zero.
- R2: With `ce_n`=0, `oe_n`=0, `we_n`=1, `ne_n`=1 and `busy` low, `data_oe` is high and `rdata` shows the RAM word at `addr` in the same cycle.
- R3: With `ce_n`=0, `we_n`=0, `ne_n`=1 and `busy` low, `wdata` is written to RAM at `addr` on the next rising edge, whatever the level of `oe_n`. While the write strobe is low, `data_oe` stays low.
- R4: With `ce_n`=0, `we_n`=0, `ne_n`=0, `oe_n`=1 and `busy` low, `sw_cmd` is high and the RAM is not written.
- R5: With all four strobes low, the inputs have no effect: no write, no output, no recall and no store.
- R6: A recall starts on the first cycle in which `ce_n`=0, `oe_n`=0, `ne_n`=0 and `we_n`=1 while idle. `busy` is then high for exactly DEPTH cycles after the start edge, and afterwards every RAM word equals its shadow word.
- R7: After reset is released, a recall runs at once. `busy` is high for exactly DEPTH cycles.
- R8: A `store_req` pulse with `oe_n` high while idle starts a store. `busy` is high for DEPTH+STORE_WAIT cycles after the start edge. The shadow array receives the RAM contents as they stand after that edge, which includes a RAM write made on the same edge.
- R9: A `store_req` is dropped when `oe_n` is low or when the block is busy. This includes the case where a recall command arrives in the same cycle.
- R10: While `busy` is high, host reads, writes and commands are ignored, and `data_oe` and `sw_cmd` stay low.
- R11: Holding the recall combination for many cycles starts only one recall. A new recall needs the combination to be released and applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| ne_n | input | 1 | Nonvolatile select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| store_req | input | 1 | Store request pulse from supply monitoring |
| rdata | output | DATA_W | Read data, zero when not driving |
| data_oe | output | 1 | Tri-state enable for the data pads |
| sw_cmd | output | 1 | A software command cycle is on the bus |
| busy | output | 1 | A recall or store is in progress |

## Verification
Two cases are provoked. In the first, a store request arrives in the same cycle as a recall command. The recall pattern holds output enable low, so the store must be dropped. This is judged by the length of the `busy` window, which must match a recall and not a store. In the second, a RAM write and a store request land on the same clock edge. The RAM is then overwritten and a recall is run, and the read of that word must return the value from the concurrent write. This shows that the store image was taken after the write.

// File: rtl/nvb_pkg.sv
// Shared types for the NV bus mode controller.
// Assumes: single clock domain; all encodings are internal to the block.
package nvb_pkg;

    // Bus mode decoded from the four active-low strobes
    typedef enum logic [2:0] {
        BM_STANDBY = 3'd0,
        BM_READ    = 3'd1,
        BM_WRITE   = 3'd2,
        BM_RECALL  = 3'd3,
        BM_SWCMD   = 3'd4,
        BM_OUTOFF  = 3'd5,
        BM_ILLEGAL = 3'd6,
        BM_NOP     = 3'd7
    } bus_mode_e;

    // Transfer sequencer state
    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_RECALL = 2'd1,
        XS_COPY   = 2'd2,
        XS_WAIT   = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/nvb_decode.sv
// Combinational decode of the four active-low bus strobes into a bus mode.
// Assumes: strobes are already synchronous to clk; write wins over output enable.
module nvb_decode
    import nvb_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      ne_n,
    output bus_mode_e mode
);

    // Map strobe combination to mode; chip select high overrides all
    always_comb begin
        if (ce_n) begin
            mode = BM_STANDBY;
        end else begin
            unique case ({we_n, ne_n, oe_n})
                3'b110:         mode = BM_READ;
                3'b010, 3'b011: mode = BM_WRITE;
                3'b100:         mode = BM_RECALL;
                3'b001:         mode = BM_SWCMD;
                3'b111:         mode = BM_OUTOFF;
                3'b000:         mode = BM_ILLEGAL;
                default:        mode = BM_NOP;
            endcase
        end
    end

endmodule

// File: rtl/nvb_xfer_seq.sv
// Sequencer for whole-array transfers: recall (shadow to RAM) and
// store (RAM to shadow followed by a programming wait).
// Assumes: reset models power-up, so reset enters recall directly;
// recall_lvl is the raw decoded recall pattern and is edge-qualified here.
module nvb_xfer_seq
    import nvb_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int STORE_WAIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recall_lvl,
    input  logic              store_req,
    input  logic              oe_n,
    output logic              busy,
    output logic              rcl_beat,
    output logic              sto_beat,
    output logic [ADDR_W-1:0] beat_addr
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WAIT_W = $clog2(STORE_WAIT + 1);
    localparam int CNT_W  = (ADDR_W > WAIT_W) ? ADDR_W : WAIT_W;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(STORE_WAIT - 1);

    xfer_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic             rcl_prev;
    logic             idle;
    logic             rcl_start;
    logic             sto_start;

    assign idle      = (state == XS_IDLE);
    assign rcl_start = idle && recall_lvl && !rcl_prev;
    assign sto_start = idle && store_req && oe_n && !recall_lvl;

    // Remember last cycle's recall pattern for edge qualification
    always_ff @(posedge clk) begin
        if (!rst_n) rcl_prev <= 1'b0;
        else        rcl_prev <= recall_lvl;
    end

    // Transfer state machine and shared beat/wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XS_RECALL;
            cnt   <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    cnt <= '0;
                    if (rcl_start)      state <= XS_RECALL;
                    else if (sto_start) state <= XS_COPY;
                end
                XS_RECALL: begin
                    if (cnt == LAST_BEAT) begin
                        state <= XS_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XS_COPY: begin
                    cnt <= (cnt == LAST_BEAT) ? '0 : cnt + 1'b1;
                    if (cnt == LAST_BEAT) state <= XS_WAIT;
                end
                default: begin
                    if (cnt == LAST_WAIT) begin
                        state <= XS_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Beat strobes and address for the array copy
    assign busy      = !idle;
    assign rcl_beat  = (state == XS_RECALL);
    assign sto_beat  = (state == XS_COPY);
    assign beat_addr = cnt[ADDR_W-1:0];

endmodule

// File: rtl/nvb_arrays.sv
// Behavioural RAM and bit-for-bit shadow array with per-beat copy paths.
// Assumes: host write and recall beat never coincide (host gated by busy);
// arrays carry no reset, as their contents are meant to persist.
module nvb_arrays #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rcl_beat,
    input  logic              sto_beat,
    input  logic [ADDR_W-1:0] beat_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram    [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];

    // RAM update: host write, else one recall beat
    always_ff @(posedge clk) begin
        if (wr_en)         ram[host_addr] <= wr_data;
        else if (rcl_beat) ram[beat_addr] <= shadow[beat_addr];
    end

    // Shadow update: one store beat per cycle
    always_ff @(posedge clk) begin
        if (sto_beat) shadow[beat_addr] <= ram[beat_addr];
    end

    assign rd_data = ram[host_addr];

endmodule

// File: rtl/nvram_bus_ctrl.sv
// Top of the NV bus mode controller: decodes strobes, gates host access
// by busy, drives the pad enable and hands whole-array transfers to the
// sequencer.
// Assumes: strobes synchronous to clk; rdata reads as zero when undriven.
module nvram_bus_ctrl
    import nvb_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int STORE_WAIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              ne_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              store_req,
    output logic [DATA_W-1:0] rdata,
    output logic              data_oe,
    output logic              sw_cmd,
    output logic              busy
);

    bus_mode_e         mode;
    logic              rcl_beat;
    logic              sto_beat;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] ram_q;
    logic              host_wr;

    nvb_decode u_dec (
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .ne_n (ne_n),
        .mode (mode)
    );

    nvb_xfer_seq #(
        .ADDR_W     (ADDR_W),
        .STORE_WAIT (STORE_WAIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_lvl (mode == BM_RECALL),
        .store_req  (store_req),
        .oe_n       (oe_n),
        .busy       (busy),
        .rcl_beat   (rcl_beat),
        .sto_beat   (sto_beat),
        .beat_addr  (beat_addr)
    );

    // Host access is only honoured while no transfer runs
    assign host_wr = (mode == BM_WRITE) && !busy;
    assign data_oe = (mode == BM_READ) && !busy;
    assign sw_cmd  = (mode == BM_SWCMD) && !busy;

    nvb_arrays #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk       (clk),
        .wr_en     (host_wr),
        .host_addr (addr),
        .wr_data   (wdata),
        .rcl_beat  (rcl_beat),
        .sto_beat  (sto_beat),
        .beat_addr (beat_addr),
        .rd_data   (ram_q)
    );

    assign rdata = data_oe ? ram_q : '0;

endmodule

// File: rtl/nvb_checker.sv
// Property checker for nvram_bus_ctrl, attached by bind.
// Assumes: observes ports only; tracks the recall pattern and busy run length itself.
module nvb_checker #(
    parameter int DEPTH      = 2048,
    parameter int STORE_WAIT = 64
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic ne_n,
    input logic store_req,
    input logic data_oe,
    input logic sw_cmd,
    input logic busy
);

    logic     rcl_pat;
    logic     rcl_seen;
    int unsigned run;

    assign rcl_pat = !ce_n && !oe_n && we_n && !ne_n;

    // Previous-cycle recall pattern
    always_ff @(posedge clk) begin
        if (!rst_n) rcl_seen <= 1'b0;
        else        rcl_seen <= rcl_pat;
    end

    // Length of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    AST_OE_RULES: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!ce_n && !oe_n && ne_n && we_n)); // R1

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!data_oe && !sw_cmd)); // R10

    AST_RECALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rcl_pat && !rcl_seen) |=> busy); // R6

    AST_RECALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rcl_pat && rcl_seen) |=> !busy); // R11

    AST_STORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && store_req && oe_n) |=> busy); // R8

    AST_STORE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && store_req && !oe_n && !rcl_pat) |=> !busy); // R9

    AST_POWERUP_RCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> busy); // R7

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run <= DEPTH + STORE_WAIT); // R8

endmodule

bind nvram_bus_ctrl nvb_checker #(
    .DEPTH      (1 << ADDR_W),
    .STORE_WAIT (STORE_WAIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .ne_n      (ne_n),
    .store_req (store_req),
    .data_oe   (data_oe),
    .sw_cmd    (sw_cmd),
    .busy      (busy)
);

// File: tb/tb_nvram_bus_ctrl.sv
// Self-checking bench: vector table for bus modes, then directed transfer tests.
module tb_nvram_bus_ctrl;

    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int SW    = 64;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ne_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          store_req = 1'b0;
    logic [DW-1:0] rdata;
    logic          data_oe, sw_cmd, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    nvram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_WAIT(SW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .ne_n(ne_n), .addr(addr), .wdata(wdata), .store_req(store_req),
        .rdata(rdata), .data_oe(data_oe), .sw_cmd(sw_cmd), .busy(busy)
    );

    typedef struct packed {
        logic          ce, oe, we, ne;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          eoe, ecmd, chk;
        logic [DW-1:0] erd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1, 11'd3, 8'h5A, 1'b0,1'b0,1'b0, 8'h00}, // R3 write
        '{1'b0,1'b1,1'b0,1'b1, 11'd9, 8'h3C, 1'b0,1'b0,1'b0, 8'h00}, // R3 write
        '{1'b0,1'b1,1'b0,1'b1, 11'd5, 8'hC3, 1'b0,1'b0,1'b0, 8'h00}, // R3 write
        '{1'b0,1'b0,1'b1,1'b1, 11'd3, 8'h00, 1'b1,1'b0,1'b1, 8'h5A}, // R2 read
        '{1'b0,1'b0,1'b1,1'b1, 11'd9, 8'h00, 1'b1,1'b0,1'b1, 8'h3C}, // R2 read
        '{1'b1,1'b0,1'b1,1'b1, 11'd3, 8'h00, 1'b0,1'b0,1'b1, 8'h00}, // R1 ce high
        '{1'b0,1'b1,1'b1,1'b1, 11'd3, 8'h00, 1'b0,1'b0,1'b1, 8'h00}, // R1 oe high
        '{1'b0,1'b1,1'b1,1'b0, 11'd3, 8'h00, 1'b0,1'b0,1'b1, 8'h00}, // R1 ne low
        '{1'b0,1'b1,1'b0,1'b0, 11'd3, 8'hFF, 1'b0,1'b1,1'b0, 8'h00}, // R4 command
        '{1'b0,1'b0,1'b1,1'b1, 11'd3, 8'h00, 1'b1,1'b0,1'b1, 8'h5A}, // R4 unchanged
        '{1'b0,1'b0,1'b0,1'b0, 11'd9, 8'h00, 1'b0,1'b0,1'b1, 8'h00}, // R5 illegal
        '{1'b0,1'b0,1'b0,1'b1, 11'd5, 8'hA1, 1'b0,1'b0,1'b1, 8'h00}, // R3 write, oe low
        '{1'b0,1'b0,1'b1,1'b1, 11'd5, 8'h00, 1'b1,1'b0,1'b1, 8'hA1}  // R3 read back
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic w, input logic n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; ne_n = n; addr = a; wdata = d;
        #5;
    endtask

    task automatic bus_idle();
        drive(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
        drive(1'b0, 1'b0, 1'b1, 1'b1, a, '0);
        check(req, rdata, e);
    endtask

    // Counts negedges after the driving negedge until busy falls
    task automatic wait_idle(output int n);
        n = 0;
        do begin
            @(negedge clk);
            store_req = 1'b0;
            n++;
        end while (busy && n < 10000);
    endtask

    initial begin
        int n;
        // R7: power-up recall
        repeat (3) @(negedge clk);
        #5;
        check("R1 reset oe", data_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R7 busy after reset", busy, 1);
        repeat (DEPTH - 1) @(negedge clk);
        check("R7 busy at last beat", busy, 1);
        @(negedge clk);
        check("R7 busy cleared", busy, 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ce, TBL[i].oe, TBL[i].we, TBL[i].ne, TBL[i].a, TBL[i].d);
            check($sformatf("R1/R2 vec%0d oe", i), data_oe, TBL[i].eoe);
            check($sformatf("R4 vec%0d cmd", i), sw_cmd, TBL[i].ecmd);
            check($sformatf("R5 vec%0d busy", i), busy, 0);
            if (TBL[i].chk) check($sformatf("R2 vec%0d data", i), rdata, TBL[i].erd);
        end

        // R8: write and store on the same edge
        @(negedge clk);
        ce_n = 0; oe_n = 1; we_n = 0; ne_n = 1; addr = 11'd5; wdata = 8'hA5; store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0; ce_n = 1; we_n = 1;
        n = 1;
        begin
            int m;
            wait_idle(m);
            n += m;
        end
        check("R8 store length", n, 1 + DEPTH + SW);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 11'd5, 8'h11);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 11'd9, 8'h44);

        // R6: commanded recall restores the stored image
        drive(1'b0, 1'b0, 1'b1, 1'b0, 11'd0, 8'h00);
        @(negedge clk);
        #5;
        check("R6 busy in recall", busy, 1);
        check("R1 oe in recall", data_oe, 0);
        wait_idle(n);
        check("R6 recall length", n, DEPTH);
        bus_idle();
        read_chk("R8 same-edge write stored", 11'd5, 8'hA5);
        read_chk("R6 recalled word", 11'd9, 8'h3C);

        // R10: host write during store is ignored
        bus_idle();
        @(negedge clk);
        store_req = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 11'd9, 8'h77);
        store_req = 1'b0;
        check("R10 busy during store", busy, 1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 11'd9, 8'h00);
        check("R10 no output while busy", data_oe, 0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 11'd9, 8'h00);
        check("R10 no command while busy", sw_cmd, 0);
        wait_idle(n);
        bus_idle();
        read_chk("R10 write ignored", 11'd9, 8'h3C);

        // R9: store with output enable low is dropped
        drive(1'b0, 1'b1, 1'b0, 1'b1, 11'd5, 8'h99);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; ne_n = 1; addr = 11'd5; store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        #5;
        check("R9 store blocked", busy, 0);
        bus_idle();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 11'd0, 8'h00);
        wait_idle(n);
        bus_idle();
        read_chk("R9 shadow untouched", 11'd5, 8'hA5);

        // R9/R6: recall and store in the same cycle -> recall only
        bus_idle();
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; ne_n = 0; store_req = 1'b1;
        wait_idle(n);
        check("R9 recall wins over store", n, 1 + DEPTH);

        // R11: held recall pattern starts nothing more
        repeat (5) @(negedge clk);
        #5;
        check("R11 no second recall", busy, 0);
        bus_idle();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 11'd0, 8'h00);
        @(negedge clk);
        #5;
        check("R11 re-armed recall", busy, 1);
        wait_idle(n);
        bus_idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule